// File: doc/BRIEF.md
# Four-Channel Serial Audio Transmitter

This block turns four parallel 24-bit sample words into bit-serial data on two output pins. It runs entirely on the falling edge of the bit clock and uses the frame clock only as a timing reference, so it works the same whether the two clocks are produced on the same chip or come from outside. A two-bit mode code picks one of three framings. Pair framing puts two channels on each pin, one per frame-clock half. Wide TDM puts all four channels in 32-bit slots on both pins, in a frame of 256 bit clocks. Narrow TDM puts all four channels on the first pin in a frame of 128 bit clocks and holds the second pin low. A format input picks the I2S framing, where the frame starts on a falling frame-clock edge and the MSB comes one bit late. When the format input is low the framing is justified, where the frame starts on a rising edge and the MSB comes at once.

The frame-start edge copies the four sample words, the mode code and the format into shadow registers, so the sources can be updated while a frame is being shifted out. A slot sequencer with four named states selects which bit is on the wire. A lane multiplexer for each pin picks the channel for that pin and drives the bit.

States: `ST_IDLE` (no frame active, pins low), `ST_LEAD` (the one quiet bit before the MSB in I2S), `ST_DATA` (the 24 word bits, MSB first), `ST_PAD` (zero fill to the end of a slot or half). Transitions: *begin* (any state to `ST_LEAD` if I2S, otherwise to `ST_DATA`, on a frame-start edge, or on the other frame-clock edge in pair framing while not idle); *lead-done* (`ST_LEAD` to `ST_DATA`); *word-done* (`ST_DATA` to `ST_PAD` after bit 23); *next-slot* (`ST_PAD` to `ST_DATA` after slot bit 31 in TDM when slots remain); *frame-done* (`ST_PAD` to `ST_IDLE` after the fourth TDM slot). In pair framing `ST_PAD` holds until the next frame-clock edge.

Top module: `qch_audio_ser`

## Requirements
- R1: Every channel word is sent as 24 bits in two's complement, MSB first, and all slot or half-frame bits after the LSB are 0.
- R2: The frame clock is sampled on each falling bit-clock edge. In justified format (`fmt_i2s`=0) the frame starts when a high level is first seen, and the MSB is driven right after that same falling edge.
- R3: In I2S format (`fmt_i2s`=1) the frame starts when a low level is first seen. The bit after that edge is 0 and the MSB follows one bit clock later. The same one-bit delay applies at the start of the second half in pair framing.
- R4: In pair framing (`tdm_mode`=00) `sdo1` carries channel 1 in the frame-start half and channel 2 in the other half, and `sdo2` carries channels 3 and 4 in the same way.
- R5: Pair framing works for any half length of at least 26 bit clocks. This covers 64 and 128 bit clocks per frame, with zeros held after the LSB until the next frame-clock edge.
- R6: In wide TDM (`tdm_mode`=01) both pins carry channels 1, 2, 3, 4 in consecutive 32-bit slots from the frame start, and are 0 for the rest of the 256-bit frame.
- R7: In narrow TDM (`tdm_mode`=10) `sdo1` carries channels 1 to 4 in consecutive 32-bit slots, and `sdo2` stays 0 for the whole frame.
- R8: In TDM modes only the frame-start edge starts a frame. The opposite frame-clock edge is ignored whether it comes after 1 bit clock or after half a frame.
- R9: Sample words are captured at the frame-start edge. Changing the sample inputs during a frame does not change the bits sent in that frame.
- R10: The mode code is captured at the frame-start edge. Changing it during a frame does not change that frame's layout.
- R11: The mode code 11 behaves as pair framing.
- R12: After reset both pins are 0 and stay 0 until the first frame-start edge. A frame-clock edge of the opposite polarity seen before that is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock; all state changes on its falling edge |
| lrck | input | 1 | Frame clock, sampled on falling bit-clock edges |
| fmt_i2s | input | 1 | 1 = I2S framing, 0 = justified framing |
| tdm_mode | input | 2 | 00 pair, 01 wide TDM, 10 narrow TDM, 11 as pair |
| smp_ch1 | input | 24 | Channel 1 sample word |
| smp_ch2 | input | 24 | Channel 2 sample word |
| smp_ch3 | input | 24 | Channel 3 sample word |
| smp_ch4 | input | 24 | Channel 4 sample word |
| sdo1 | output | 1 | First serial data pin |
| sdo2 | output | 1 | Second serial data pin |

## Verification
The bench builds the block with its default 24-bit word and 32-bit slot. This means every bit position of every slot and half-frame, including the zero padding, is compared against a value computed arithmetically. The sweep covers each mode code, both formats, two pair-framing lengths, and both half-frame and one-bit frame-clock pulses in TDM, with extreme and random sample patterns. In every frame the bench overwrites the sample and mode inputs after a few bits, so the shadow capture is exercised in each configuration.

// File: rtl/qch_pkg.sv
`timescale 1ns/1ps
package qch_pkg;

    typedef enum logic [1:0] {
        MODE_PAIR       = 2'b00,
        MODE_TDM_WIDE   = 2'b01,
        MODE_TDM_NARROW = 2'b10,
        MODE_RSVD       = 2'b11
    } frame_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_DATA = 2'd2,
        ST_PAD  = 2'd3
    } tx_state_e;

    function automatic logic is_tdm(frame_mode_e m);
        return (m == MODE_TDM_WIDE) || (m == MODE_TDM_NARROW);
    endfunction

endpackage

// File: rtl/qch_frame_sync.sv
`timescale 1ns/1ps
module qch_frame_sync
    import qch_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int NUM_CH = 4,
    localparam int BUS_W = WORD_W * NUM_CH
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              lrck,
    input  logic              fmt_i2s,
    input  frame_mode_e       mode_in,
    input  logic [BUS_W-1:0]  smp_in,
    output logic              edge_seen,
    output logic              frame_start,
    output logic              eff_i2s,
    output frame_mode_e       eff_mode,
    output frame_mode_e       cfg_mode,
    output logic [BUS_W-1:0]  smp_hold
);

    logic        lrck_q;
    logic        cfg_i2s;

    // An edge is any change of the frame clock between two falling bit-clock edges.
    always_comb begin
        edge_seen   = lrck ^ lrck_q;
        frame_start = edge_seen && (lrck == ~fmt_i2s);
        eff_i2s     = frame_start ? fmt_i2s : cfg_i2s;
        eff_mode    = frame_start ? mode_in : cfg_mode;
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            lrck_q   <= 1'b0;
            cfg_i2s  <= 1'b0;
            cfg_mode <= MODE_PAIR;
            smp_hold <= '0;
        end else begin
            lrck_q <= lrck;
            if (frame_start) begin
                cfg_i2s  <= fmt_i2s;
                cfg_mode <= mode_in;
                smp_hold <= smp_in;
            end
        end
    end

    // R9: shadow words only move on a frame-start edge
    a_r9_shadow_hold: assert property (@(negedge bclk) disable iff (!rst_n)
        !frame_start |=> $stable(smp_hold));

    // R10: captured configuration only moves on a frame-start edge
    a_r10_cfg_hold: assert property (@(negedge bclk) disable iff (!rst_n)
        !frame_start |=> ($stable(cfg_mode) && $stable(cfg_i2s)));

endmodule

// File: rtl/qch_slot_fsm.sv
`timescale 1ns/1ps
module qch_slot_fsm
    import qch_pkg::*;
#(
    parameter int WORD_W    = 24,
    parameter int SLOT_W    = 32,
    parameter int NUM_SLOTS = 4,
    localparam int POS_W    = $clog2(SLOT_W),
    localparam int SLOT_IW  = $clog2(NUM_SLOTS)
) (
    input  logic               bclk,
    input  logic               rst_n,
    input  logic               edge_seen,
    input  logic               frame_start,
    input  logic               eff_i2s,
    input  frame_mode_e        eff_mode,
    output tx_state_e          state_q,
    output logic [POS_W-1:0]   pos_q,
    output logic [SLOT_IW-1:0] slot_q
);

    localparam logic [POS_W-1:0]   LAST_BIT  = POS_W'(WORD_W - 1);
    localparam logic [POS_W-1:0]   LAST_POS  = POS_W'(SLOT_W - 1);
    localparam logic [SLOT_IW-1:0] LAST_SLOT = SLOT_IW'(NUM_SLOTS - 1);

    tx_state_e          state_d;
    logic [POS_W-1:0]   pos_d;
    logic [SLOT_IW-1:0] slot_d;
    logic               begin_evt;

    always_comb begin
        state_d   = state_q;
        pos_d     = pos_q;
        slot_d    = slot_q;
        begin_evt = frame_start ||
                    (edge_seen && !is_tdm(eff_mode) && (state_q != ST_IDLE));
        if (begin_evt) begin
            state_d = eff_i2s ? ST_LEAD : ST_DATA;
            pos_d   = '0;
            slot_d  = frame_start ? '0 : SLOT_IW'(1);
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_LEAD: begin
                    state_d = ST_DATA;
                    pos_d   = '0;
                end
                ST_DATA: begin
                    pos_d = pos_q + 1'b1;
                    if (pos_q == LAST_BIT) begin
                        state_d = ST_PAD;
                    end
                end
                ST_PAD: begin
                    if (is_tdm(eff_mode)) begin
                        if (pos_q == LAST_POS) begin
                            pos_d = '0;
                            if (slot_q == LAST_SLOT) begin
                                state_d = ST_IDLE;
                            end else begin
                                slot_d  = slot_q + 1'b1;
                                state_d = ST_DATA;
                            end
                        end else begin
                            pos_d = pos_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            slot_q  <= slot_d;
        end
    end

    // R3: the quiet lead bit lasts exactly one bit clock
    a_r3_lead_one_bit: assert property (@(negedge bclk) disable iff (!rst_n)
        (state_q == ST_LEAD && !edge_seen) |=> (state_q == ST_DATA && pos_q == '0));

    // R1: word bits advance one position per bit clock
    a_r1_data_run: assert property (@(negedge bclk) disable iff (!rst_n)
        (state_q == ST_DATA && pos_q < LAST_BIT && !edge_seen)
        |=> (state_q == ST_DATA && pos_q == POS_W'($past(pos_q) + 1'b1)));

    // R8: in TDM a non-start edge does not wake an idle sequencer
    a_r8_tdm_edge_ignored: assert property (@(negedge bclk) disable iff (!rst_n)
        (state_q == ST_IDLE && edge_seen && !frame_start && is_tdm(eff_mode))
        |=> (state_q == ST_IDLE));

    // R5: pair framing pads until the next frame-clock edge
    a_r5_pad_holds: assert property (@(negedge bclk) disable iff (!rst_n)
        (state_q == ST_PAD && !edge_seen && !is_tdm(eff_mode)) |=> (state_q == ST_PAD));

endmodule

// File: rtl/qch_lane_mux.sv
`timescale 1ns/1ps
module qch_lane_mux
    import qch_pkg::*;
#(
    parameter int WORD_W    = 24,
    parameter int NUM_CH    = 4,
    parameter int SLOT_W    = 32,
    parameter int LANE      = 0,
    localparam int BUS_W    = WORD_W * NUM_CH,
    localparam int POS_W    = $clog2(SLOT_W),
    localparam int SLOT_IW  = $clog2(NUM_CH),
    localparam int CH_PER_L = NUM_CH / 2
) (
    input  logic               bclk,
    input  logic               rst_n,
    input  tx_state_e          state_q,
    input  logic [POS_W-1:0]   pos_q,
    input  logic [SLOT_IW-1:0] slot_q,
    input  frame_mode_e        cfg_mode,
    input  logic [BUS_W-1:0]   smp_hold,
    output logic               sdo
);

    int   ch_sel;
    int   bit_idx;
    logic lane_live;

    always_comb begin
        if (is_tdm(cfg_mode)) begin
            ch_sel    = int'(slot_q);
            lane_live = !((LANE == 1) && (cfg_mode == MODE_TDM_NARROW));
        end else begin
            ch_sel    = LANE * CH_PER_L + int'(slot_q[0]);
            lane_live = 1'b1;
        end
        bit_idx = ch_sel * WORD_W + (WORD_W - 1) - int'(pos_q);
        sdo     = 1'b0;
        if ((state_q == ST_DATA) && lane_live && (int'(pos_q) < WORD_W)) begin
            sdo = smp_hold[bit_idx];
        end
    end

    // R12: an idle lane is quiet
    a_r12_idle_quiet: assert property (@(negedge bclk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sdo);

    // R3: the I2S lead bit is quiet
    a_r3_lead_quiet: assert property (@(negedge bclk) disable iff (!rst_n)
        (state_q == ST_LEAD) |-> !sdo);

    if (LANE == 1) begin : g_second_pin
        // R7: second pin silent through a narrow TDM frame
        a_r7_narrow_low: assert property (@(negedge bclk) disable iff (!rst_n)
            (cfg_mode == MODE_TDM_NARROW) |-> !sdo);
    end

endmodule

// File: rtl/qch_audio_ser.sv
`timescale 1ns/1ps
module qch_audio_ser
    import qch_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int SLOT_W = 32
) (
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              lrck,
    input  logic              fmt_i2s,
    input  logic [1:0]        tdm_mode,
    input  logic [WORD_W-1:0] smp_ch1,
    input  logic [WORD_W-1:0] smp_ch2,
    input  logic [WORD_W-1:0] smp_ch3,
    input  logic [WORD_W-1:0] smp_ch4,
    output logic              sdo1,
    output logic              sdo2
);

    localparam int NUM_CH   = 4;
    localparam int NUM_PINS = 2;
    localparam int BUS_W    = WORD_W * NUM_CH;
    localparam int POS_W    = $clog2(SLOT_W);
    localparam int SLOT_IW  = $clog2(NUM_CH);

    logic [BUS_W-1:0]    smp_bus;
    logic [BUS_W-1:0]    smp_hold;
    logic                edge_seen;
    logic                frame_start;
    logic                eff_i2s;
    frame_mode_e         eff_mode;
    frame_mode_e         cfg_mode;
    tx_state_e           state_q;
    logic [POS_W-1:0]    pos_q;
    logic [SLOT_IW-1:0]  slot_q;
    logic [NUM_PINS-1:0] sdo_vec;

    assign smp_bus = {smp_ch4, smp_ch3, smp_ch2, smp_ch1};

    qch_frame_sync #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_sync (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .lrck        (lrck),
        .fmt_i2s     (fmt_i2s),
        .mode_in     (frame_mode_e'(tdm_mode)),
        .smp_in      (smp_bus),
        .edge_seen   (edge_seen),
        .frame_start (frame_start),
        .eff_i2s     (eff_i2s),
        .eff_mode    (eff_mode),
        .cfg_mode    (cfg_mode),
        .smp_hold    (smp_hold)
    );

    qch_slot_fsm #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_CH)) u_fsm (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .edge_seen   (edge_seen),
        .frame_start (frame_start),
        .eff_i2s     (eff_i2s),
        .eff_mode    (eff_mode),
        .state_q     (state_q),
        .pos_q       (pos_q),
        .slot_q      (slot_q)
    );

    for (genvar ln = 0; ln < NUM_PINS; ln++) begin : g_lane
        qch_lane_mux #(
            .WORD_W (WORD_W),
            .NUM_CH (NUM_CH),
            .SLOT_W (SLOT_W),
            .LANE   (ln)
        ) u_lane (
            .bclk     (bclk),
            .rst_n    (rst_n),
            .state_q  (state_q),
            .pos_q    (pos_q),
            .slot_q   (slot_q),
            .cfg_mode (cfg_mode),
            .smp_hold (smp_hold),
            .sdo      (sdo_vec[ln])
        );
    end

    assign sdo1 = sdo_vec[0];
    assign sdo2 = sdo_vec[1];

endmodule

// File: tb/tb_qch_audio_ser.sv
`timescale 1ns/1ps
module tb_qch_audio_ser;

    localparam int CLK_PERIOD = 20;
    localparam int WDOG_CYC   = 150000;

    logic        rst_n;
    logic        bclk;
    logic        lrck;
    logic        fmt_i2s;
    logic [1:0]  tdm_mode;
    logic [23:0] s1, s2, s3, s4;
    logic        sdo1, sdo2;

    int checks = 0;
    int errors = 0;

    qch_audio_ser dut (
        .rst_n    (rst_n),
        .bclk     (bclk),
        .lrck     (lrck),
        .fmt_i2s  (fmt_i2s),
        .tdm_mode (tdm_mode),
        .smp_ch1  (s1),
        .smp_ch2  (s2),
        .smp_ch3  (s3),
        .smp_ch4  (s4),
        .sdo1     (sdo1),
        .sdo2     (sdo2)
    );

    initial bclk = 1'b0;
    always #(CLK_PERIOD / 2) bclk = ~bclk;

    task automatic chk(input logic act, input logic exp, input string tag,
                       input int md, input bit i2s, input int n, input int lane);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s md=%0d i2s=%0b bit=%0d lane=%0d act=%0b exp=%0b",
                     tag, md, i2s, n, lane, act, exp);
        end
    endtask

    // Expected bit n after the frame-start edge, derived from the requirements.
    function automatic logic exp_bit(logic [95:0] w, int md, bit i2s, int half,
                                     int n, int lane);
        int d, ch, b;
        if (md == 1 || md == 2) begin
            if (lane == 1 && md == 2) return 1'b0;
            d = n - int'(i2s);
            if (d < 0) return 1'b0;
            ch = d / 32;
            b  = d % 32;
            if (ch > 3 || b >= 24) return 1'b0;
            return w[ch * 24 + 23 - b];
        end
        if (n < half) begin
            d  = n - int'(i2s);
            ch = lane * 2;
        end else begin
            d  = n - half - int'(i2s);
            ch = lane * 2 + 1;
        end
        if (d < 0 || d >= 24) return 1'b0;
        return w[ch * 24 + 23 - d];
    endfunction

    function automatic string tag_for(int md, bit i2s, int bpf, int lane);
        string t;
        case (md)
            1:       t = "R6 R8";
            2:       t = (lane == 1) ? "R7" : "R7 R8";
            3:       t = "R11";
            default: t = (bpf == 128) ? "R5 R4" : "R4";
        endcase
        t = {t, i2s ? " R3" : " R2", " R1 R9 R10"};
        return t;
    endfunction

    task automatic run_frame(input int md, input bit i2s, input int bpf,
                             input int hi, input logic [95:0] w);
        logic slvl;
        logic act;
        slvl     = ~i2s;
        fmt_i2s  = i2s;
        tdm_mode = md[1:0];
        {s4, s3, s2, s1} = w;
        if (lrck == slvl) begin
            repeat (2) begin
                @(posedge bclk);
                lrck = ~slvl;
            end
        end
        for (int n = 0; n <= bpf; n++) begin
            @(posedge bclk);
            if (n > 0) begin
                for (int ln = 0; ln < 2; ln++) begin
                    act = (ln == 0) ? sdo1 : sdo2;
                    chk(act, exp_bit(w, md, i2s, hi, n - 1, ln),
                        tag_for(md, i2s, bpf, ln), md, i2s, n - 1, ln);
                end
            end
            if (n < bpf) lrck = (n < hi) ? slvl : ~slvl;
            if (n == 5) begin
                // R9 R10: disturb inputs mid-frame
                {s4, s3, s2, s1} = ~w ^ 96'h5A5A5A_C3C3C3_0F0F0F_969696;
                tdm_mode = (md == 1 || md == 2) ? 2'b00 : 2'b01;
            end
        end
    endtask

    function automatic logic [95:0] pattern(int p);
        logic [95:0] w;
        case (p)
            0: w = {24'h7FFFFF, 24'h800000, 24'h7FFFFF, 24'h800000};
            1: w = {24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF};
            2: w = {24'h000001, 24'h400000, 24'hA5A5A5, 24'h123456};
            default: w = {$urandom, $urandom, $urandom};
        endcase
        return w;
    endfunction

    initial begin
        #(CLK_PERIOD * WDOG_CYC);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cfg_md [7]  = '{0, 0, 3, 1, 1, 2, 2};
        int cfg_bpf[7]  = '{64, 128, 64, 256, 256, 128, 128};
        int cfg_hi [7]  = '{32, 64, 32, 128, 1, 64, 1};
        rst_n    = 1'b0;
        lrck     = 1'b0;
        fmt_i2s  = 1'b0;
        tdm_mode = 2'b00;
        {s4, s3, s2, s1} = {24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF};
        repeat (3) @(posedge bclk);
        rst_n = 1'b1;

        // R12: quiet after reset, lrck low with justified format
        for (int i = 0; i < 6; i++) begin
            @(posedge bclk);
            chk(sdo1, 1'b0, "R12", 0, 1'b0, i, 0);
            chk(sdo2, 1'b0, "R12", 0, 1'b0, i, 1);
        end
        // R12: a rising edge in I2S format is not a frame start
        fmt_i2s = 1'b1;
        lrck    = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(posedge bclk);
            chk(sdo1, 1'b0, "R12", 0, 1'b1, i, 0);
            chk(sdo2, 1'b0, "R12", 0, 1'b1, i, 1);
        end

        for (int f = 0; f < 2; f++) begin
            for (int c = 0; c < 7; c++) begin
                for (int p = 0; p < 4; p++) begin
                    run_frame(cfg_md[c], f[0], cfg_bpf[c], cfg_hi[c], pattern(p));
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule